// File: doc/BRIEF.md
# Key-Protected Two-Stage Watchdog

The block is a watchdog timer with one write-only control word. The word holds a 7-bit key, a run bit and a 9-bit count field. The run bit is also the most significant bit of the count field. Once a stored word has its run bit set, software must prove that it is alive. It does this with a new write whose key is the bitwise inverse of the key it wrote last time. A write that carries any other key is dropped with no effect.

The countdown advances on a slow tick strobe. This tick is about 760 Hz in a system, and it comes from outside the block. When the count runs out the first time, the block raises a non-maskable interrupt (NMI) and reloads a short grace count. The countdown keeps running. If the grace count also runs out before software services the watchdog, the block raises a system reset request. That request holds until the block itself is reset.

An accepted write reloads the countdown from the count field of the word that was stored before the write. A field of zero loads 256. The countdown then runs or stops as the new run bit says, and the new word is stored.

Top module: `wdt_keyed`

## Requirements
- R1: After reset, `nmi_o` and `sys_rst_req_o` are low, the countdown is stopped, and the stored word is all zeros. With no write, no number of ticks raises either output.
- R2: The stored run bit is bit 8 of the stored word. While it is 1, a write is accepted only if its bits [15:9] equal the bitwise inverse of the stored bits [15:9]. Any other write changes nothing: not the countdown, not the stored word, not `nmi_o`.
- R3: While the stored bit 8 is 0, every write is accepted whatever its key.
- R4: An accepted write loads the countdown from bits [8:0] of the previously stored word. A value of 0 loads 256.
- R5: After an accepted write, the countdown runs if bit 8 of the written data is 1 and stays stopped if it is 0. A stopped countdown never expires.
- R6: A running countdown loaded with N expires on the Nth cycle in which `tick_i` is high.
- R7: On the first expiry, `nmi_o` goes high in the next cycle. The countdown reloads GRACE_TICKS (default 10) and keeps running.
- R8: An expiry while the NMI stage is active sets `sys_rst_req_o`. It then stays high until `rst_n` is asserted, even across accepted writes.
- R9: An accepted write lowers `nmi_o` and clears the NMI stage, so the next expiry raises an NMI again rather than a reset request.
- R10: When a write is accepted in the same cycle as a tick, the reload wins and that tick causes no expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_data_i | input | 16 | Control word: [15:9] key, [8] run, [8:0] count |
| tick_i | input | 1 | Slow tick enable, one cycle wide per tick |
| nmi_o | output | 1 | Non-maskable interrupt, first-stage expiry |
| sys_rst_req_o | output | 1 | Sticky system reset request, second-stage expiry |

## Verification
The assertions assume that `wr_data_i` is known whenever `wr_en_i` is high, and that reset is applied before the first write. They also assume that `tick_i` is a strobe the bench controls. The assertions do not depend on how often ticks come. The stimulus changes every input only at the falling clock edge and gives each tick as a one-cycle pulse. Writes are one-cycle strobes. One scenario deliberately sets a tick and a write in the same cycle, to cover the priority rule.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;
    localparam int KEY_W  = 7;
    localparam int CNT_W  = 9;
    localparam int CTRL_W = KEY_W + CNT_W;
    localparam logic [CNT_W-1:0] ZERO_LOAD = CNT_W'(1) << (CNT_W - 1);

    // Key sits above the count; the count's top bit is the run command.
    typedef struct packed {
        logic [KEY_W-1:0] key;
        logic [CNT_W-1:0] cnt;
    } wdt_ctrl_t;
endpackage

// File: rtl/wdt_keygate.sv
`timescale 1ns/1ps
module wdt_keygate
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  wdt_ctrl_t        wr_data_i,
    output logic             accept_o,
    output logic [CNT_W-1:0] load_val_o,
    output logic             load_run_o,
    output wdt_ctrl_t        ctrl_o
);
    typedef struct packed {
        wdt_ctrl_t ctrl;
    } gate_st_t;

    gate_st_t st_d, st_q;
    logic     armed;
    logic     key_ok;

    always_comb begin
        st_d       = st_q;
        armed      = st_q.ctrl.cnt[CNT_W-1];
        key_ok     = (wr_data_i.key == ~st_q.ctrl.key);
        accept_o   = wr_en_i && (!armed || key_ok);
        load_val_o = (st_q.ctrl.cnt == '0) ? ZERO_LOAD : st_q.ctrl.cnt;
        load_run_o = wr_data_i.cnt[CNT_W-1];
        if (accept_o) begin
            st_d.ctrl = wr_data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl_o = st_q.ctrl;
endmodule

// File: rtl/wdt_countdown.sv
`timescale 1ns/1ps
module wdt_countdown
    import wdt_pkg::*;
#(
    parameter int GRACE_TICKS = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             load_run_i,
    input  logic             tick_i,
    input  logic             stage_i,
    output logic             expire_o,
    output logic             run_o,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] GRACE_LD = CNT_W'(GRACE_TICKS);

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
    } cd_st_t;

    cd_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        expire_o = 1'b0;
        if (load_i) begin
            st_d.cnt = load_val_i;
            st_d.run = load_run_i;
        end else if (st_q.run && tick_i) begin
            if (st_q.cnt == CNT_W'(1)) begin
                expire_o = 1'b1;
                if (stage_i) begin
                    st_d.run = 1'b0;
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = GRACE_LD;
                end
            end else begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign run_o = st_q.run;
    assign cnt_o = st_q.cnt;
endmodule

// File: rtl/wdt_escalate.sv
`timescale 1ns/1ps
module wdt_escalate (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic expire_i,
    output logic stage_o,
    output logic nmi_o,
    output logic rst_req_o
);
    typedef struct packed {
        logic stage;
        logic nmi;
        logic rst_req;
    } esc_st_t;

    esc_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (expire_i) begin
            if (!st_q.stage) begin
                st_d.stage = 1'b1;
                st_d.nmi   = 1'b1;
            end else begin
                st_d.rst_req = 1'b1;
            end
        end
        if (clear_i) begin
            st_d.stage = 1'b0;
            st_d.nmi   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stage_o   = st_q.stage;
    assign nmi_o     = st_q.nmi;
    assign rst_req_o = st_q.rst_req;
endmodule

// File: rtl/wdt_keyed.sv
`timescale 1ns/1ps
module wdt_keyed
    import wdt_pkg::*;
#(
    parameter int GRACE_TICKS = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [CTRL_W-1:0] wr_data_i,
    input  logic              tick_i,
    output logic              nmi_o,
    output logic              sys_rst_req_o
);
    logic             accept;
    logic [CNT_W-1:0] load_val;
    logic             load_run;
    wdt_ctrl_t        ctrl_q;
    logic             expire;
    logic             run_q;
    logic [CNT_W-1:0] cnt_q;
    logic             stage_q;

    wdt_keygate u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en_i),
        .wr_data_i  (wdt_ctrl_t'(wr_data_i)),
        .accept_o   (accept),
        .load_val_o (load_val),
        .load_run_o (load_run),
        .ctrl_o     (ctrl_q)
    );

    wdt_countdown #(.GRACE_TICKS(GRACE_TICKS)) u_cd (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (accept),
        .load_val_i (load_val),
        .load_run_i (load_run),
        .tick_i     (tick_i),
        .stage_i    (stage_q),
        .expire_o   (expire),
        .run_o      (run_q),
        .cnt_o      (cnt_q)
    );

    wdt_escalate u_esc (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (accept),
        .expire_i  (expire),
        .stage_o   (stage_q),
        .nmi_o     (nmi_o),
        .rst_req_o (sys_rst_req_o)
    );
endmodule

// File: rtl/wdt_keyed_chk.sv
`timescale 1ns/1ps
module wdt_keyed_chk
    import wdt_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             accept,
    input logic             expire,
    input logic             run,
    input logic [CNT_W-1:0] cnt,
    input logic [CTRL_W-1:0] ctrl,
    input logic             nmi,
    input logic             rst_req
);
    // R8: reset request is sticky
    a_r8_rst_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> rst_req);
    // R8: reset request only follows an active NMI stage
    a_r8_rst_after_nmi: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> $past(nmi));
    // R7: NMI rises only after an expiry
    a_r7_nmi_from_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi) |-> $past(expire));
    // R9: accepted write drops the NMI
    a_r9_write_clears_nmi: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !nmi);
    // R2: rejected write leaves the stored word alone
    a_r2_reject_keeps_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !accept) |=> $stable(ctrl));
    // R6: a running countdown never sits at zero
    a_r6_run_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt != '0));
    // R10: no expiry in a cycle with an accepted write
    a_r10_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> !expire);
endmodule

bind wdt_keyed wdt_keyed_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en_i),
    .accept  (accept),
    .expire  (expire),
    .run     (run_q),
    .cnt     (cnt_q),
    .ctrl    (ctrl_q),
    .nmi     (nmi_o),
    .rst_req (sys_rst_req_o)
);

// File: tb/sim_wdt_keyed.sv
`timescale 1ns/1ps
module sim_wdt_keyed;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        tick = 1'b0;
    logic        nmi;
    logic        rreq;
    int          n_chk = 0;
    int          n_fail = 0;

    always #2 clk = ~clk;

    wdt_keyed u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en_i       (wr_en),
        .wr_data_i     (wr_data),
        .tick_i        (tick),
        .nmi_o         (nmi),
        .sys_rst_req_o (rreq)
    );

    function automatic logic [15:0] word(input logic [6:0] key, input logic [8:0] c);
        return {key, c};
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; tick = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic do_write(input logic [15:0] d, input logic with_tick);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d; tick = with_tick;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = 1'b1;
        end
        @(negedge clk);
        tick = 1'b0;
    endtask

    // R1: idle after reset
    task automatic t_reset_state();
        do_reset();
        check("R1 nmi after reset", nmi, 1'b0);
        check("R1 rreq after reset", rreq, 1'b0);
        ticks(300);
        check("R1 stopped, no nmi", nmi, 1'b0);
    endtask

    // R3 R4 R6 R7 R2 R8: zero count loads 256, then escalation
    task automatic t_zero_load_escalate();
        do_reset();
        do_write(word(7'h15, 9'h100), 1'b0);  // R3 any key, R4 loads 256
        ticks(255);
        check("R4 no nmi at 255", nmi, 1'b0);
        ticks(1);
        check("R6 R7 nmi at 256", nmi, 1'b1);
        do_write(word(7'h15, 9'h000), 1'b0);  // R2 wrong key, ignored
        check("R2 ignored write keeps nmi", nmi, 1'b1);
        ticks(9);
        check("R7 grace not done", rreq, 1'b0);
        ticks(1);
        check("R8 rreq after grace", rreq, 1'b1);
        do_write(word(7'h6A, 9'h000), 1'b0);  // accepted
        check("R9 nmi cleared", nmi, 1'b0);
        check("R8 rreq sticky", rreq, 1'b1);
        do_reset();
        check("R1 reset clears rreq", rreq, 1'b0);
    endtask

    // R3 R4 R6 R9 R5
    task automatic t_service_stop();
        do_reset();
        do_write(word(7'h11, 9'h005), 1'b0);  // stopped, stores count 5
        ticks(300);
        check("R5 stopped no expiry", nmi, 1'b0);
        do_write(word(7'h22, 9'h105), 1'b0);  // R3 any key, loads 5
        ticks(4);
        check("R6 no nmi at 4", nmi, 1'b0);
        ticks(1);
        check("R6 nmi at 5", nmi, 1'b1);
        do_write(word(7'h5D, 9'h105), 1'b0);  // inverse key, loads 261
        check("R9 service clears nmi", nmi, 1'b0);
        ticks(260);
        check("R4 no nmi at 260", nmi, 1'b0);
        ticks(1);
        check("R4 nmi at 261", nmi, 1'b1);
        do_write(word(7'h22, 9'h105), 1'b0);
        ticks(261);
        check("R9 stage cleared: nmi again", nmi, 1'b1);
        check("R9 stage cleared: no rreq", rreq, 1'b0);
        do_write(word(7'h5D, 9'h005), 1'b0);  // accepted, run 0
        ticks(400);
        check("R5 stop command", nmi, 1'b0);
        check("R5 stop command rreq", rreq, 1'b0);
        do_write(word(7'h00, 9'h105), 1'b0);  // R3 disarmed, loads 5
        ticks(5);
        check("R3 any key when disarmed", nmi, 1'b1);
    endtask

    // R10: write in same cycle as a tick
    task automatic t_same_cycle();
        do_write(word(7'h7F, 9'h105), 1'b0);  // key inverse of 0, loads 261
        ticks(260);
        check("R10 pre nmi low", nmi, 1'b0);
        do_write(word(7'h00, 9'h105), 1'b1);  // reload wins over last tick
        check("R10 no expiry on load", nmi, 1'b0);
        ticks(260);
        check("R10 reload full count", nmi, 1'b0);
        ticks(1);
        check("R10 expiry after reload", nmi, 1'b1);
    endtask

    initial begin
        t_reset_state();
        t_zero_load_escalate();
        t_service_stop();
        t_same_cycle();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(4 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule